// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Overflow Pulse

This block multiplies two operands and adds the product to a running accumulator every cycle in which its output stage is enabled. Each operand is first widened to the smallest native multiplier width (9, 18 or 36 bits) that holds it. A mode input decides how the widening is done: zero-fill for unsigned operands, sign extension for two's-complement ones. The same mode input also picks the roll-over rule for the accumulator.

When the accumulator wraps, the block raises a one-cycle overflow pulse. A small up/down counter of these pulses forms an upper word above the accumulator, so the pair reads as one wider result. For signed arithmetic the counter steps down on a negative roll-over. A load input replaces the accumulation with a given value and clears the upper word.

The datapath has three register stages: input, pipeline and output. Each stage takes its clock enable from one of four enable sources and its synchronous reset from one of four reset sources. The choices are fixed by parameters.

Top module: `mac_ovf_pulse`

## Requirements
- R1: Each operand is widened to the native width NAT_W (9 if the wider operand is at most 9 bits, 18 if at most 18, else 36). When `is_signed` is 0 the widening fills with zeros. When it is 1 the widening copies the operand's top bit. With 8-bit operands, 0xFF times 2 adds 510 in unsigned mode and adds -2 in signed mode.
- R2: An operand pair presented before rising edge k affects `acc_out` after edge k+2. The input, pipeline and output stages each add one register.
- R3: In unsigned mode, `ovf` is 1 after an accumulation whose ACC_W-bit result is smaller than the previous accumulator value. For example, 2^ACC_W-10 plus 20 gives 10 with `ovf`=1.
- R4: In signed mode, `ovf` is 1 after an accumulation in either of two cases: a non-negative accumulator plus a non-negative addend gives a negative result, or a negative accumulator plus a negative addend gives a non-negative result. The wrap points are +2^(ACC_W-1)-1 and -2^(ACC_W-1).
- R5: `ovf` is high for exactly one cycle per roll-over. It is never high in two consecutive cycles.
- R6: {`acc_hi`, `acc_out`} equals the exact sum modulo 2^(CNT_W+ACC_W). In unsigned mode the count steps up on each roll-over. In signed mode it steps up when the addend is non-negative and down when the addend is negative, and {`acc_hi`,`acc_out`} reads as two's complement.
- R7: When `load` reaches the output stage, the accumulator takes `load_val` and `ovf` stays 0. The upper word is cleared, so it reads 0, or all ones in signed mode when the top bit of `load_val` is 1. No product is added in that cycle.
- R8: While the enable source chosen for a stage is 0, that stage's registers hold their values. While the output stage is disabled, `acc_out` holds and `ovf` is 0.
- R9: The reset source chosen for a stage clears that stage synchronously: `acc_out`, `acc_hi` and `ovf` become 0. A reset source that no stage selects has no effect.
- R10: `is_signed` and `load` are captured with the operands in the input stage. They travel with that operand pair through the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| ce_src | input | 4 | Four clock-enable sources |
| rst_src | input | 4 | Four synchronous active-high reset sources |
| op_a | input | A_W | Operand A |
| op_b | input | B_W | Operand B |
| is_signed | input | 1 | 1: two's-complement operands and signed roll-over rule |
| load | input | 1 | Replace accumulation with `load_val` |
| load_val | input | ACC_W | Value to load |
| acc_out | output | ACC_W | Accumulator |
| acc_hi | output | CNT_W | Upper word built from roll-over count |
| ovf | output | 1 | One-cycle roll-over pulse |

## Verification
The hardest situations to reach from the ports are a signed accumulator crossing its wrap point in both directions, and a load landing on a cycle where the add would have rolled over. Reaching them by accumulation alone takes dozens of cycles. The stimulus therefore loads values a few units away from each wrap point and then adds small products of the needed sign. It also runs long streams of maximum-magnitude products, so the upper word counts up and back down through several roll-overs. Every scoreboard item compares the accumulator, the upper word and the pulse against a wide reference sum.

// File: rtl/mac_ovf_pulse.sv
module mac_ovf_pulse #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int ACC_W = 20,
  parameter int CNT_W = 4,
  parameter bit EXT_EN = 1'b1,
  parameter int IN_CE_SEL = 0,
  parameter int PIPE_CE_SEL = 1,
  parameter int OUT_CE_SEL = 2,
  parameter int IN_RST_SEL = 0,
  parameter int PIPE_RST_SEL = 1,
  parameter int OUT_RST_SEL = 3
) (
  input  logic             clk,
  input  logic [3:0]       ce_src,
  input  logic [3:0]       rst_src,
  input  logic [A_W-1:0]   op_a,
  input  logic [B_W-1:0]   op_b,
  input  logic             is_signed,
  input  logic             load,
  input  logic [ACC_W-1:0] load_val,
  output logic [ACC_W-1:0] acc_out,
  output logic [CNT_W-1:0] acc_hi,
  output logic             ovf
);
  localparam int MAX_W  = (A_W > B_W) ? A_W : B_W;
  localparam int NAT_W  = (MAX_W <= 9) ? 9 : ((MAX_W <= 18) ? 18 : 36);
  localparam int PROD_W = 2 * NAT_W;
  localparam int T      = ACC_W - 1;

  wire ce_in = ce_src[IN_CE_SEL];
  wire ce_pp = ce_src[PIPE_CE_SEL];
  wire ce_ou = ce_src[OUT_CE_SEL];
  wire rs_in = rst_src[IN_RST_SEL];
  wire rs_pp = rst_src[PIPE_RST_SEL];
  wire rs_ou = rst_src[OUT_RST_SEL];

  // input stage
  logic [A_W-1:0]   in_a;
  logic [B_W-1:0]   in_b;
  logic             in_sgn, in_ld;
  logic [ACC_W-1:0] in_lv;

  always_ff @(posedge clk) begin
    if (rs_in) begin
      in_a <= '0; in_b <= '0; in_sgn <= 1'b0; in_ld <= 1'b0; in_lv <= '0;
    end else if (ce_in) begin
      in_a <= op_a; in_b <= op_b; in_sgn <= is_signed; in_ld <= load; in_lv <= load_val;
    end
  end

  // widening to native width, then multiply
  logic signed [NAT_W:0]    a_nat, b_nat;
  logic signed [PROD_W+1:0] prod_full;
  assign a_nat     = (NAT_W+1)'($signed({in_sgn & in_a[A_W-1], in_a}));
  assign b_nat     = (NAT_W+1)'($signed({in_sgn & in_b[B_W-1], in_b}));
  assign prod_full = a_nat * b_nat;

  // pipeline stage
  logic [PROD_W-1:0] pp_prod;
  logic              pp_sgn, pp_ld;
  logic [ACC_W-1:0]  pp_lv;

  always_ff @(posedge clk) begin
    if (rs_pp) begin
      pp_prod <= '0; pp_sgn <= 1'b0; pp_ld <= 1'b0; pp_lv <= '0;
    end else if (ce_pp) begin
      pp_prod <= prod_full[PROD_W-1:0]; pp_sgn <= in_sgn; pp_ld <= in_ld; pp_lv <= in_lv;
    end
  end

  // accumulate and detect roll-over
  logic [ACC_W-1:0] addend, sum, acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, sgn_q, wrap;

  assign addend = pp_sgn ? ACC_W'($signed(pp_prod)) : ACC_W'(pp_prod);
  assign sum    = acc_q + addend;
  assign wrap   = pp_sgn ? ((acc_q[T] == addend[T]) && (sum[T] != acc_q[T]))
                         : (sum < acc_q);

  always_ff @(posedge clk) begin
    if (rs_ou) begin
      acc_q <= '0; cnt_q <= '0; ovf_q <= 1'b0; sgn_q <= 1'b0;
    end else if (ce_ou) begin
      sgn_q <= pp_sgn;
      if (pp_ld) begin
        acc_q <= pp_lv; cnt_q <= '0; ovf_q <= 1'b0;
      end else begin
        acc_q <= sum; ovf_q <= wrap;
        if (wrap) cnt_q <= (pp_sgn && addend[T]) ? cnt_q - 1'b1 : cnt_q + 1'b1;
      end
    end else begin
      ovf_q <= 1'b0;
    end
  end

  assign acc_out = acc_q;
  assign ovf     = ovf_q;

  generate
    if (EXT_EN) begin : g_ext
      assign acc_hi = cnt_q - CNT_W'(sgn_q & acc_q[T]);
    end else begin : g_noext
      assign acc_hi = '0;
    end
  endgenerate

  // checks
  p_unsigned_wrap_r3: assert property (@(posedge clk) disable iff (rs_ou)
    (ovf_q && !sgn_q) |-> (acc_q < $past(acc_q)));

  p_signed_wrap_r4: assert property (@(posedge clk) disable iff (rs_ou)
    (ovf_q && sgn_q) |-> (acc_q[T] != $past(acc_q[T])));

  generate
    if (ACC_W > PROD_W) begin : g_pulse_chk
      p_one_cycle_r5: assert property (@(posedge clk) disable iff (rs_ou)
        ovf_q |=> !ovf_q);
    end
  endgenerate

  p_count_up_r6: assert property (@(posedge clk) disable iff (rs_ou)
    (ovf_q && !sgn_q) |-> (cnt_q == $past(cnt_q) + 1'b1));

  p_load_r7: assert property (@(posedge clk) disable iff (rs_ou)
    (ce_ou && pp_ld) |=> (!ovf_q && acc_q == $past(pp_lv) && cnt_q == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (rs_ou)
    !ce_ou |=> ($stable(acc_q) && !ovf_q));
endmodule

// File: tb/mac_ovf_pulse_test.sv
module mac_ovf_pulse_test;
  localparam int AW = 8, BW = 8, ACW = 20, CW = 4;

  logic clk = 1'b0;
  logic [3:0] ce_src = 4'hF, rst_src = 4'hF;
  logic [AW-1:0] op_a = '0;
  logic [BW-1:0] op_b = '0;
  logic is_signed = 1'b0, load = 1'b0;
  logic [ACW-1:0] load_val = '0;
  logic [ACW-1:0] acc_out;
  logic [CW-1:0] acc_hi;
  logic ovf;

  mac_ovf_pulse uut (.clk(clk), .ce_src(ce_src), .rst_src(rst_src), .op_a(op_a), .op_b(op_b),
    .is_signed(is_signed), .load(load), .load_val(load_val), .acc_out(acc_out),
    .acc_hi(acc_hi), .ovf(ovf));

  always #10 clk = ~clk;

  typedef struct {
    int unsigned due;
    string tag;
    logic [ACW-1:0] e_acc;
    logic [CW-1:0] e_hi;
    logic e_ovf;
  } item_t;

  item_t q[$];
  int unsigned cyc = 0;
  int checks = 0, fails = 0;
  longint ref_sum = 0;
  bit ref_sgn = 0;
  bit prev_ovf = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, bit ok, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint seg(longint v, bit s);
    return s ? ((v + (longint'(1) <<< (ACW-1))) >>> ACW) : (v >>> ACW);
  endfunction

  task automatic push(string tag, logic [AW-1:0] a, logic [BW-1:0] b, bit s, bit ld,
                      logic [ACW-1:0] lv);
    item_t it;
    longint old;
    @(negedge clk);
    op_a = a; op_b = b; is_signed = s; load = ld; load_val = lv;
    old = ref_sum;
    if (ld) begin
      ref_sgn = s;
      ref_sum = s ? longint'($signed(lv)) : longint'(lv);
      it.e_ovf = 1'b0;
    end else begin
      ref_sum += s ? longint'($signed(a)) * longint'($signed(b)) : longint'(a) * longint'(b);
      it.e_ovf = (seg(ref_sum, s) != seg(old, s));
    end
    it.due = cyc + 3;
    it.tag = tag;
    it.e_acc = ref_sum[ACW-1:0];
    it.e_hi = ref_sum[ACW+CW-1:ACW];
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    #1;
    if (ovf) check("R5", !prev_ovf, {prev_ovf, ovf}, 2'b01);
    prev_ovf = ovf;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, acc_out == it.e_acc && acc_hi == it.e_hi && ovf == it.e_ovf,
            {acc_hi, acc_out, 3'b0, ovf}, {it.e_hi, it.e_acc, 3'b0, it.e_ovf});
    end
  end

  task automatic drain();
    repeat (4) push("R2", 8'd0, 8'd0, ref_sgn, 1'b0, '0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    logic [ACW-1:0] held;
    repeat (3) @(negedge clk);
    rst_src = 4'h0;
    #1;
    check("R9 reset", acc_out == 0 && acc_hi == 0 && ovf == 0, {acc_hi, acc_out, ovf}, 0);

    // R1/R10: widening follows the mode sampled with the operands
    push("R7", 8'd0, 8'd0, 1'b0, 1'b1, '0);
    push("R1 unsigned", 8'hFF, 8'd2, 1'b0, 1'b0, '0);
    push("R7", 8'd0, 8'd0, 1'b1, 1'b1, '0);
    push("R1 signed", 8'hFF, 8'd2, 1'b1, 1'b0, '0);
    push("R10", 8'hFF, 8'hFF, 1'b1, 1'b0, '0);

    // R3/R6: unsigned stream of maximum products
    push("R7", 8'd0, 8'd0, 1'b0, 1'b1, '0);
    for (int i = 0; i < 40; i++) push("R3 R6", 8'hFF, 8'hFF, 1'b0, 1'b0, '0);

    // R4/R6: signed up through the wrap, then down through both
    push("R7", 8'd0, 8'd0, 1'b1, 1'b1, '0);
    for (int i = 0; i < 36; i++) push("R4 R6 up", 8'd127, 8'd127, 1'b1, 1'b0, '0);
    for (int i = 0; i < 75; i++) push("R4 R6 down", 8'h80, 8'd127, 1'b1, 1'b0, '0);

    // boundary loads
    push("R7", 8'd0, 8'd0, 1'b0, 1'b1, ACW'((1 << ACW) - 10));
    push("R3 edge", 8'd4, 8'd5, 1'b0, 1'b0, '0);
    push("R7", 8'd0, 8'd0, 1'b1, 1'b1, ACW'((1 << (ACW-1)) - 5));
    push("R4 pos edge", 8'd3, 8'd3, 1'b1, 1'b0, '0);
    push("R7", 8'd0, 8'd0, 1'b1, 1'b1, ACW'(-(1 << (ACW-1)) + 3));
    push("R4 neg edge", 8'hFE, 8'd3, 1'b1, 1'b0, '0);
    // R7: load where an add would have wrapped
    push("R7", 8'd0, 8'd0, 1'b0, 1'b1, ACW'((1 << ACW) - 2));
    push("R7 no pulse", 8'd9, 8'd9, 1'b0, 1'b1, ACW'(123));
    push("R7 signed neg", 8'd9, 8'd9, 1'b1, 1'b1, ACW'(-7));

    // mixed stream
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 19) == 0)
        push("R7 rnd", AW'($urandom), BW'($urandom), 1'($urandom), 1'b1, ACW'($urandom));
      else
        push("R6 rnd", AW'($urandom), BW'($urandom), ref_sgn, 1'b0, '0);
    end
    drain();

    // R8: output stage disabled
    @(negedge clk);
    held = acc_out;
    op_a = 8'd100; op_b = 8'd100; ce_src[2] = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R8 out hold", acc_out == held && !ovf, {acc_out, ovf}, {held, 1'b0});
    end
    ce_src[2] = 1'b1; op_a = 8'd0; op_b = 8'd0;
    @(negedge clk); #1;
    check("R8 out resume", acc_out == held + ACW'(10000), acc_out, held + ACW'(10000));
    repeat (4) @(negedge clk);

    // R8: input stage disabled keeps zero operands
    held = acc_out;
    ce_src[0] = 1'b0; op_a = 8'd100; op_b = 8'd100;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check("R8 in hold", acc_out == held, acc_out, held);
    end
    ce_src[0] = 1'b1; op_a = 8'd0; op_b = 8'd0;
    repeat (3) @(negedge clk);

    // R9: unused reset source, then the output reset
    held = acc_out;
    rst_src[2] = 1'b1;
    repeat (2) begin
      @(negedge clk); #1;
      check("R9 unused rst", acc_out == held, acc_out, held);
    end
    rst_src[2] = 1'b0; rst_src[3] = 1'b1;
    @(negedge clk); #1;
    check("R9 out rst", acc_out == 0 && acc_hi == 0 && ovf == 0, {acc_hi, acc_out, ovf}, 0);
    rst_src[3] = 1'b0;

    push("R7", 8'd0, 8'd0, 1'b0, 1'b1, ACW'(55));
    push("R2", 8'd6, 8'd7, 1'b0, 1'b0, '0);
    drain();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule